// File: doc/BRIEF.md
# Parallel Window Integral-Image Fetch Router

This block feeds a row of window kernels that sit at horizontally adjacent positions in a scaled integral-image tile. Kernel 0 is at some column of the tile, and each further kernel is one column to the right. Each cycle, every kernel receives its integral-image word from a single memory access. The tile is stored in rows of `LANES` words (one chunk). Two identical RAM copies are kept. One copy is read at the addressed chunk and the other at the chunk after it. The resulting span of 2×`LANES` words goes through a registered selector, which extracts the `LANES` consecutive words that begin at the requested offset.

Each RAM copy is split into two halves that take turns. A writer, the integral-image generator, fills one half while the reader, the kernel scan, consumes the other. A half-select bit names the writer's half, and the reader always uses the opposite half. The bit flips on a swap pulse, and only when both sides report they are done. The word width is a parameter: 21 bits suits a plain integral image and 29 bits suits a squared one.

Top module: `iiwin_fetch`

## Requirements
- R1: While `rst` is high and after it is released, `mem_state` reads 0 and `win_valid` reads 0 until a read is issued.
- R2: `win_valid` is high in exactly the cycle two clock edges after an edge that sampled `rd_en` high. Back-to-back reads give one result per cycle.
- R3: `rd_addr` is {chunk, offset}, with the offset in its low log2(`LANES`) bits. Lane i of `win_words` (bits i*`WORD_W` upward) carries word chunk*`LANES`+offset+i of the reader's half. For example, chunk 0 with offset 3 gives words 3 through 18 on lanes 0 through 15.
- R4: An offset of 0 returns exactly the `LANES` words of the addressed chunk, in order.
- R5: Lanes that reach past the addressed chunk take their words from the next chunk. Past the last chunk of a half, the read wraps to chunk 0 of the same half.
- R6: A write with `wr_en` stores `wr_row` as chunk `wr_chunk` of the writer's half, with lane j holding word chunk*`LANES`+j. The writer's half is the lower half when `mem_state` is 0 and the upper half when it is 1. The reader always uses the other half, so writes never change what reads return.
- R7: `mem_state` inverts on the edge after one where `swap`, `wr_done` and `rd_done` are all sampled high. A `swap` pulse without both done flags leaves it unchanged.
- R8: After a swap, reads at any chunk and offset return exactly the words written into that half during the previous period, including reads that span two chunks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one chunk into the writer's half |
| wr_chunk | input | CHUNK_W | Chunk index written |
| wr_row | input | LANES*WORD_W | Chunk words, lane 0 in the low bits |
| rd_en | input | 1 | Issue a window read |
| rd_addr | input | CHUNK_W+log2(LANES) | {chunk, start offset} |
| swap | input | 1 | Single-cycle request to exchange halves |
| wr_done | input | 1 | Writer has finished its half |
| rd_done | input | 1 | Reader has finished its half |
| mem_state | output | 1 | Writer's half (0 lower, 1 upper) |
| win_valid | output | 1 | `win_words` holds a read result |
| win_words | output | LANES*WORD_W | Words for kernels 0..LANES-1, lane 0 in the low bits |

## Verification
The assertions assume that `rd_en` is low while reset is held. This keeps the latency check from looking back at a read that reset has cancelled. They also assume that the done flags and `swap` are plain levels sampled at the clock. The stimulus holds every input at zero during reset and changes inputs only on the falling edge. It never makes a read depend on the writer's half, because the write traffic goes to the half that is not being read. That way the reference model sees no ordering hazard inside a cycle.

// File: rtl/iiwin_pkg.sv
package iiwin_pkg;
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;

  function automatic half_e other_half(input half_e h);
    return (h == HALF_LO) ? HALF_HI : HALF_LO;
  endfunction
endpackage

// File: rtl/iiwin_chunk_ram.sv
module iiwin_chunk_ram #(
  parameter int ROW_W  = 336,
  parameter int ROW_AW = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ROW_AW-1:0] waddr,
  input  logic [ROW_W-1:0]  wdata,
  input  logic              re,
  input  logic [ROW_AW-1:0] raddr,
  output logic [ROW_W-1:0]  rdata
);
  localparam int DEPTH = 1 << ROW_AW;

  logic [ROW_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/iiwin_addr_gen.sv
module iiwin_addr_gen #(
  parameter int CHUNK_W = 8,
  parameter int OFF_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_en,
  input  logic [CHUNK_W+OFF_W-1:0] rd_addr,
  input  logic                     rd_half,
  output logic [CHUNK_W:0]         lo_row,
  output logic [CHUNK_W:0]         hi_row,
  output logic [OFF_W-1:0]         off_q,
  output logic                     vld_q
);
  logic [CHUNK_W-1:0] base_chunk;
  logic [CHUNK_W-1:0] next_chunk;

  // next chunk wraps inside the same half through the natural width
  always_comb begin
    base_chunk = rd_addr[CHUNK_W+OFF_W-1:OFF_W];
    next_chunk = base_chunk + CHUNK_W'(1);
    lo_row     = {rd_half, base_chunk};
    hi_row     = {rd_half, next_chunk};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      off_q <= '0;
    end else begin
      vld_q <= rd_en;
      if (rd_en) off_q <= rd_addr[OFF_W-1:0];
    end
  end
endmodule

// File: rtl/iiwin_word_sel.sv
module iiwin_word_sel #(
  parameter int LANES  = 16,
  parameter int WORD_W = 21
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_vld,
  input  logic [$clog2(LANES)-1:0]    off,
  input  logic [2*LANES*WORD_W-1:0]   span,
  output logic                        out_vld,
  output logic [LANES*WORD_W-1:0]     out_words
);
  localparam int OFF_W = $clog2(LANES);
  localparam int IDX_W = OFF_W + 1;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [IDX_W-1:0] LANE_POS = IDX_W'(i);
    logic [IDX_W-1:0] idx;

    assign idx = {1'b0, off} + LANE_POS;

    always_ff @(posedge clk) begin
      if (in_vld) out_words[i*WORD_W +: WORD_W] <= span[int'(idx)*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= in_vld;
  end
endmodule

// File: rtl/iiwin_bank_ctl.sv
module iiwin_bank_ctl
  import iiwin_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  swap,
  input  logic  wr_done,
  input  logic  rd_done,
  output half_e wr_half,
  output half_e rd_half
);
  half_e state_q;

  always_ff @(posedge clk) begin
    if (rst)                            state_q <= HALF_LO;
    else if (swap && wr_done && rd_done) state_q <= other_half(state_q);
  end

  assign wr_half = state_q;
  assign rd_half = other_half(state_q);
endmodule

// File: rtl/iiwin_fetch.sv
module iiwin_fetch
  import iiwin_pkg::*;
#(
  parameter int LANES   = 16,
  parameter int WORD_W  = 21,
  parameter int CHUNK_W = 8
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  wr_en,
  input  logic [CHUNK_W-1:0]                    wr_chunk,
  input  logic [LANES*WORD_W-1:0]               wr_row,
  input  logic                                  rd_en,
  input  logic [CHUNK_W+$clog2(LANES)-1:0]      rd_addr,
  input  logic                                  swap,
  input  logic                                  wr_done,
  input  logic                                  rd_done,
  output logic                                  mem_state,
  output logic                                  win_valid,
  output logic [LANES*WORD_W-1:0]               win_words
);
  localparam int OFF_W  = $clog2(LANES);
  localparam int ROW_W  = LANES * WORD_W;
  localparam int ROW_AW = CHUNK_W + 1;
  localparam int COPIES = 2;

  half_e              wr_half;
  half_e              rd_half;
  logic [ROW_AW-1:0]  lo_row;
  logic [ROW_AW-1:0]  hi_row;
  logic [OFF_W-1:0]   off_q;
  logic               vld_q;
  logic [ROW_AW-1:0]  rd_row [COPIES];
  logic [ROW_W-1:0]   rd_data [COPIES];
  logic [2*ROW_W-1:0] span;

  iiwin_bank_ctl u_bank (
    .clk     (clk),
    .rst     (rst),
    .swap    (swap),
    .wr_done (wr_done),
    .rd_done (rd_done),
    .wr_half (wr_half),
    .rd_half (rd_half)
  );

  iiwin_addr_gen #(
    .CHUNK_W (CHUNK_W),
    .OFF_W   (OFF_W)
  ) u_addr (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_half (rd_half),
    .lo_row  (lo_row),
    .hi_row  (hi_row),
    .off_q   (off_q),
    .vld_q   (vld_q)
  );

  assign rd_row[0] = lo_row;
  assign rd_row[1] = hi_row;

  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    iiwin_chunk_ram #(
      .ROW_W  (ROW_W),
      .ROW_AW (ROW_AW)
    ) u_ram (
      .clk   (clk),
      .we    (wr_en),
      .waddr ({wr_half, wr_chunk}),
      .wdata (wr_row),
      .re    (rd_en),
      .raddr (rd_row[c]),
      .rdata (rd_data[c])
    );
  end

  assign span = {rd_data[1], rd_data[0]};

  iiwin_word_sel #(
    .LANES  (LANES),
    .WORD_W (WORD_W)
  ) u_sel (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (vld_q),
    .off       (off_q),
    .span      (span),
    .out_vld   (win_valid),
    .out_words (win_words)
  );

  assign mem_state = wr_half;
endmodule

// File: rtl/iiwin_fetch_chk.sv
module iiwin_fetch_chk (
  input logic clk,
  input logic rst,
  input logic rd_en,
  input logic swap,
  input logic wr_done,
  input logic rd_done,
  input logic mem_state,
  input logic win_valid
);
  // R2: a result only appears two edges after a sampled read
  assert_valid_has_read_R2: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> $past(rd_en, 2));

  // R2: every read outside reset yields a result two edges later
  assert_read_gives_valid_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en, 2) && !$past(rst, 1) && !$past(rst, 2)) |-> win_valid);

  // R7: half select holds unless a qualified swap was sampled
  assert_state_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(swap && wr_done && rd_done)) |-> $stable(mem_state));

  // R7: a qualified swap flips the half select
  assert_state_flips_R7: assert property (@(posedge clk) disable iff (rst)
    (swap && wr_done && rd_done) |=> (mem_state != $past(mem_state)));

  // R1: no result while reset is held
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> !win_valid);
endmodule

bind iiwin_fetch iiwin_fetch_chk u_chk (.*);

// File: tb/sim_iiwin_fetch.sv
module sim_iiwin_fetch;
  localparam int LANES   = 16;
  localparam int WORD_W  = 21;
  localparam int CHUNK_W = 8;
  localparam int OFF_W   = 4;
  localparam int ROW_W   = LANES * WORD_W;
  localparam int NCH     = 1 << CHUNK_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [CHUNK_W-1:0] wr_chunk = '0;
  logic [ROW_W-1:0] wr_row = '0;
  logic rd_en = 1'b0;
  logic [CHUNK_W+OFF_W-1:0] rd_addr = '0;
  logic swap = 1'b0, wr_done = 1'b0, rd_done = 1'b0;
  logic mem_state, win_valid;
  logic [ROW_W-1:0] win_words;

  int ntests = 0, nfail = 0;
  bit checking = 0;
  string phase = "R1";

  iiwin_fetch #(.LANES(LANES), .WORD_W(WORD_W), .CHUNK_W(CHUNK_W)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_chunk(wr_chunk), .wr_row(wr_row),
    .rd_en(rd_en), .rd_addr(rd_addr), .swap(swap), .wr_done(wr_done),
    .rd_done(rd_done), .mem_state(mem_state), .win_valid(win_valid),
    .win_words(win_words)
  );

  always #4 clk = ~clk;

  // behavioural reference: word store keyed by half*NCH*LANES + word index
  logic [WORD_W-1:0] mdl [int];
  bit st = 0;
  bit pv1 = 0, pv2 = 0;
  logic [WORD_W-1:0] pw1 [LANES];
  logic [WORD_W-1:0] pw2 [LANES];

  function automatic logic [WORD_W-1:0] wval(int h, int idx);
    return WORD_W'(h * 777777 + idx * 2654435 + 12345);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      st = 0; pv1 = 0; pv2 = 0;
    end else begin
      pv2 = pv1;
      pw2 = pw1;
      pv1 = rd_en;
      if (rd_en) begin
        for (int i = 0; i < LANES; i++) begin
          int ch, off, pos, h, key;
          ch  = int'(rd_addr[OFF_W +: CHUNK_W]);
          off = int'(rd_addr[OFF_W-1:0]);
          pos = off + i;
          h   = st ? 0 : 1;
          key = (h * NCH + ((ch + pos / LANES) % NCH)) * LANES + pos % LANES;
          pw1[i] = mdl.exists(key) ? mdl[key] : 'x;
        end
      end
      if (wr_en)
        for (int j = 0; j < LANES; j++)
          mdl[(int'(st) * NCH + int'(wr_chunk)) * LANES + j] = wr_row[j*WORD_W +: WORD_W];
      if (swap && wr_done && rd_done) st = !st;
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      ntests++;
      if (mem_state !== st || win_valid !== pv2) begin
        nfail++;
        $display("FAIL %s: mem_state/valid actual %b/%b expected %b/%b",
                 phase, mem_state, win_valid, st, pv2);
      end else if (pv2) begin
        for (int i = 0; i < LANES; i++)
          if (win_words[i*WORD_W +: WORD_W] !== pw2[i]) begin
            nfail++;
            $display("FAIL %s: lane %0d actual %h expected %h",
                     phase, i, win_words[i*WORD_W +: WORD_W], pw2[i]);
            break;
          end
      end
    end
  end

  task automatic check_state(string req, bit exp);
    ntests++;
    if (mem_state !== exp) begin
      nfail++;
      $display("FAIL %s: mem_state actual %b expected %b", req, mem_state, exp);
    end
  endtask

  task automatic put_chunk(int ch, int h);
    wr_en = 1'b1;
    wr_chunk = CHUNK_W'(ch);
    for (int j = 0; j < LANES; j++) wr_row[j*WORD_W +: WORD_W] = wval(h, ch * LANES + j);
  endtask

  task automatic do_read(int ch, int off);
    rd_en = 1'b1;
    rd_addr = {CHUNK_W'(ch), OFF_W'(off)};
    @(negedge clk);
    rd_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_swap(bit wd, bit rdn);
    swap = 1'b1; wr_done = wd; rd_done = rdn;
    @(negedge clk);
    swap = 1'b0; wr_done = 1'b0; rd_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    ntests++;
    if (mem_state !== 1'b0 || win_valid !== 1'b0) begin
      nfail++;
      $display("FAIL R1: reset state actual %b/%b expected 0/0", mem_state, win_valid);
    end
    rst = 1'b0;
    checking = 1;
    @(negedge clk);
    check_state("R1", 1'b0);

    phase = "R6";
    for (int ch = 0; ch < NCH; ch++) begin
      put_chunk(ch, 0);
      @(negedge clk);
    end
    wr_en = 1'b0;
    @(negedge clk);

    phase = "R7";
    pulse_swap(1'b1, 1'b0);
    check_state("R7", 1'b0);
    pulse_swap(1'b0, 1'b1);
    check_state("R7", 1'b0);
    wr_done = 1'b1; rd_done = 1'b1;
    @(negedge clk);
    wr_done = 1'b0; rd_done = 1'b0;
    check_state("R7", 1'b0);
    pulse_swap(1'b1, 1'b1);
    check_state("R7", 1'b1);

    phase = "R3"; do_read(0, 3);
    phase = "R4"; do_read(5, 0);
    phase = "R5"; do_read(NCH - 1, 15);
    do_read(10, 9);

    // back-to-back reads of the lower half while the upper half is filled
    phase = "R2";
    for (int k = 0; k < 200; k++) begin
      rd_en = 1'b1;
      rd_addr = CHUNK_W'($urandom_range(0, NCH - 1)) * LANES + OFF_W'($urandom_range(0, LANES - 1));
      put_chunk(k, 1);
      @(negedge clk);
    end
    rd_en = 1'b0;
    phase = "R6";
    for (int ch = 200; ch < NCH; ch++) begin
      put_chunk(ch, 1);
      @(negedge clk);
    end
    wr_en = 1'b0;
    do_read(199, 7);

    phase = "R7";
    pulse_swap(1'b1, 1'b1);
    check_state("R7", 1'b0);

    phase = "R8";
    for (int k = 0; k < 200; k++) begin
      rd_en = 1'b1;
      rd_addr = {CHUNK_W'($urandom_range(0, NCH - 1)), OFF_W'($urandom_range(0, LANES - 1))};
      @(negedge clk);
    end
    rd_en = 1'b0;
    do_read(NCH - 1, 15);
    do_read(0, 3);
    repeat (4) @(negedge clk);

    checking = 0;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule